// File: doc/BRIEF.md
# Frame Buffer Control Register File

This block is the software-facing control and status register file for a video frame buffer engine. It sits beside either the frame writer or the frame reader half of the datapath, and a parameter chooses which personality it takes. Software reaches it through a simple word-addressed register bus. The datapath drives single-cycle event strobes into it. The block returns a run enable, a sticky interrupt, a one-cycle acknowledge pulse, frame descriptor values and a few configuration fields.

In the writer personality, the block records the descriptor and buffer address of each stored frame and marks it available. It then holds that record unchanged until software acknowledges the frame, which releases the buffer for reuse. In the reader personality, software loads the descriptor and start address of the next frame to fetch. Software also sees the engine's readiness and its maximum frame size there. The two counters sit at the same addresses in both personalities but count different events.

Top module: `fbuf_ctrl_regs`

## Requirements
- R1: Word 0 bit 0 is the run enable, driven on `go_o` and read back at the same bit. It resets to 0 when `RUN_CTRL` is 1 and to 1 when `RUN_CTRL` is 0. A write to word 0 loads it from write-data bit 0.
- R2: Word 1 bit 0 reads the current `dp_busy` input and its other bits read 0. Writes to word 1 have no effect.
- R3: Word 2 bit 0 is a sticky interrupt flag and `irq_o` follows it. It is set by `evt_stored` in the writer personality and by `evt_fetched` in the reader personality. Writing 1 to bit 0 clears it. When a set and a clear meet in the same cycle, the flag stays set.
- R4: Word 3 counts frames and word 4 counts losses, each by one per strobe, and both wrap at 2^CNT_W. In the writer personality, word 3 counts `evt_stored` and word 4 counts `evt_dropped`. In the reader personality, word 3 counts `evt_fetched` and word 4 counts `evt_repeated`. Strobes meant for the other personality and writes to words 3 and 4 leave both counters unchanged.
- R5: In the writer personality, `evt_stored` captures the capture inputs when no frame is available, and the available flag then goes to 1. Word 5 reads as available in bit 31, 0 in bit 30, interlace in 29:26, width in 25:13 and height in 12:0. Word 6 reads the captured address. `frame_word_o`, `frame_addr_o` and `frame_avail_o` carry the same values. While a frame is available, further `evt_stored` strobes do not change the record. Software writes to words 5 and 6 are ignored.
- R6: In the writer personality, writing 1 to word 8 bit 0 clears the available flag and raises `ack_o` for the one following cycle. Bit 0 always reads 0. If the acknowledge and `evt_stored` fall in the same cycle, the new frame is captured and stays available. In the reader personality, such a write raises no pulse.
- R7: In the reader personality, word 5 bits 29:0 and all of word 6 are written by software and drive `frame_word_o` and `frame_addr_o`. Word 5 bits 31:30 read 0. Word 7 reads `rd_ready` in bit 26, `MAX_W` in bits 25:13 and `MAX_H` in bits 12:0. In the writer personality, word 7 reads 0.
- R8: Word 8 bit 1 is the user-packet affinity flag, which drives `affinity_o` and resets to 0. Bits 27:16 hold the frame delay, which drives `delay_o` and resets to 1. A written delay of 0 is stored as 1, and 1 to 4095 is stored as written.
- R9: `bus_rdata` loads the addressed word on the clock edge where `bus_rd` is high and holds it otherwise. Words 9 to 15 and all unused bits read 0. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| evt_stored | input | 1 | Writer finished storing a frame |
| evt_fetched | input | 1 | Reader finished fetching a frame |
| evt_dropped | input | 1 | Writer dropped a frame |
| evt_repeated | input | 1 | Reader repeated a frame |
| dp_busy | input | 1 | Datapath busy status |
| cap_ilace | input | 4 | Interlace flags of the stored frame |
| cap_width | input | 13 | Width of the stored frame |
| cap_height | input | 13 | Height of the stored frame |
| cap_addr | input | 32 | Buffer start address of the stored frame |
| rd_ready | input | 1 | Reader can take the next frame's details |
| go_o | output | 1 | Run enable |
| irq_o | output | 1 | Interrupt line |
| ack_o | output | 1 | One-cycle frame acknowledge pulse |
| frame_avail_o | output | 1 | Writer frame available |
| frame_word_o | output | 32 | Frame descriptor word |
| frame_addr_o | output | 32 | Frame start address |
| affinity_o | output | 1 | User-packet affinity flag |
| delay_o | output | 12 | Frame delay |

## Verification
Every registered result of a bus write or event strobe shows at the outputs one cycle after the strobe. This covers the run enable, the flag, the counters, the captured record and the configuration fields. Read data also arrives one cycle after `bus_rd`, and `ack_o` is high only in the cycle after the acknowledging write. The bench drives each stimulus for exactly one cycle from a falling edge and samples at the following falling edge. It computes expected read data from its model before applying that cycle's updates, because a read returns the value held before the edge.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

  localparam int FLD_DIM_W = 13;
  localparam int FLD_IL_W  = 4;
  localparam int DELAY_W   = 12;
  localparam int FIELDS_W  = FLD_IL_W + 2 * FLD_DIM_W;

  localparam int OFS_CTRL  = 0;
  localparam int OFS_STAT  = 1;
  localparam int OFS_IRQ   = 2;
  localparam int OFS_FCNT  = 3;
  localparam int OFS_LCNT  = 4;
  localparam int OFS_INFO  = 5;
  localparam int OFS_ADDR  = 6;
  localparam int OFS_CAPS  = 7;
  localparam int OFS_MISC  = 8;

  function automatic logic [31:0] pack_info(input logic avail,
                                            input logic [FIELDS_W-1:0] fields);
    return {avail, 1'b0, fields};
  endfunction

  function automatic logic [31:0] pack_caps(input logic ready,
                                            input logic [FLD_DIM_W-1:0] w,
                                            input logic [FLD_DIM_W-1:0] h);
    return {5'b0, ready, w, h};
  endfunction

  function automatic logic [31:0] pack_misc(input logic aff,
                                            input logic [DELAY_W-1:0] dly);
    return {4'b0, dly, 14'b0, aff, 1'b0};
  endfunction

  function automatic logic [DELAY_W-1:0] norm_delay(input logic [DELAY_W-1:0] d);
    return (d == '0) ? DELAY_W'(1) : d;
  endfunction

endpackage

// File: rtl/fbc_event_counter.sv
module fbc_event_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_o <= '0;
    else if (inc_i) count_o <= count_o + CNT_W'(1);
  end
endmodule

// File: rtl/fbc_sticky_flag.sv
module fbc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= set_i | (flag_o & ~clr_i);
  end
endmodule

// File: rtl/fbc_frame_slot.sv
module fbc_frame_slot
  import fbc_pkg::*;
#(
  parameter bit IS_READER = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_i,
  input  logic                ack_i,
  input  logic [FIELDS_W-1:0] cap_fields_i,
  input  logic [31:0]         cap_addr_i,
  input  logic                sw_info_we_i,
  input  logic                sw_addr_we_i,
  input  logic [31:0]         sw_wdata_i,
  output logic                accept_o,
  output logic                avail_o,
  output logic [FIELDS_W-1:0] fields_o,
  output logic [31:0]         addr_o
);
  generate
    if (IS_READER) begin : g_reader
      assign accept_o = 1'b0;
      assign avail_o  = 1'b0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          fields_o <= '0;
          addr_o   <= '0;
        end else begin
          if (sw_info_we_i) fields_o <= sw_wdata_i[FIELDS_W-1:0];
          if (sw_addr_we_i) addr_o   <= sw_wdata_i;
        end
      end
    end else begin : g_writer
      logic avail_q;
      assign accept_o = cap_i & (~avail_q | ack_i);
      assign avail_o  = avail_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          avail_q  <= 1'b0;
          fields_o <= '0;
          addr_o   <= '0;
        end else begin
          avail_q <= accept_o | (avail_q & ~ack_i);
          if (accept_o) begin
            fields_o <= cap_fields_i;
            addr_o   <= cap_addr_i;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/fbuf_ctrl_regs.sv
module fbuf_ctrl_regs
  import fbc_pkg::*;
#(
  parameter bit IS_READER = 1'b0,
  parameter bit RUN_CTRL  = 1'b1,
  parameter int ADDR_W    = 4,
  parameter int CNT_W     = 32,
  parameter int MAX_W     = 1920,
  parameter int MAX_H     = 1080
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 evt_stored,
  input  logic                 evt_fetched,
  input  logic                 evt_dropped,
  input  logic                 evt_repeated,
  input  logic                 dp_busy,
  input  logic [FLD_IL_W-1:0]  cap_ilace,
  input  logic [FLD_DIM_W-1:0] cap_width,
  input  logic [FLD_DIM_W-1:0] cap_height,
  input  logic [31:0]          cap_addr,
  input  logic                 rd_ready,
  output logic                 go_o,
  output logic                 irq_o,
  output logic                 ack_o,
  output logic                 frame_avail_o,
  output logic [31:0]          frame_word_o,
  output logic [31:0]          frame_addr_o,
  output logic                 affinity_o,
  output logic [DELAY_W-1:0]   delay_o
);
  localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] AD_IRQ  = ADDR_W'(OFS_IRQ);
  localparam logic [ADDR_W-1:0] AD_FCNT = ADDR_W'(OFS_FCNT);
  localparam logic [ADDR_W-1:0] AD_LCNT = ADDR_W'(OFS_LCNT);
  localparam logic [ADDR_W-1:0] AD_INFO = ADDR_W'(OFS_INFO);
  localparam logic [ADDR_W-1:0] AD_ADDR = ADDR_W'(OFS_ADDR);
  localparam logic [ADDR_W-1:0] AD_CAPS = ADDR_W'(OFS_CAPS);
  localparam logic [ADDR_W-1:0] AD_MISC = ADDR_W'(OFS_MISC);
  localparam logic [FLD_DIM_W-1:0] CAP_W = FLD_DIM_W'(MAX_W);
  localparam logic [FLD_DIM_W-1:0] CAP_H = FLD_DIM_W'(MAX_H);

  // Named internal events for the checker
  logic wr_ctrl, wr_irq, wr_info, wr_addr, wr_misc;
  logic irq_set, irq_clr, ack_fire, frm_inc, loss_inc, cap_accept;
  logic role_rd;
  logic [CNT_W-1:0] frame_cnt, loss_cnt;
  logic [31:0] fcnt_word, lcnt_word, rd_word;
  logic [FIELDS_W-1:0] slot_fields;
  logic go_q, aff_q, ack_q;
  logic [DELAY_W-1:0] dly_q;

  assign role_rd = IS_READER;

  assign wr_ctrl = bus_wr && (bus_addr == AD_CTRL);
  assign wr_irq  = bus_wr && (bus_addr == AD_IRQ);
  assign wr_info = bus_wr && (bus_addr == AD_INFO);
  assign wr_addr = bus_wr && (bus_addr == AD_ADDR);
  assign wr_misc = bus_wr && (bus_addr == AD_MISC);

  assign irq_clr = wr_irq && bus_wdata[0];

  generate
    if (IS_READER) begin : g_rd_events
      assign irq_set  = evt_fetched;
      assign frm_inc  = evt_fetched;
      assign loss_inc = evt_repeated;
      assign ack_fire = 1'b0;
    end else begin : g_wr_events
      assign irq_set  = evt_stored;
      assign frm_inc  = evt_stored;
      assign loss_inc = evt_dropped;
      assign ack_fire = wr_misc && bus_wdata[0];
    end
  endgenerate

  fbc_event_counter #(.CNT_W(CNT_W)) u_frame_cnt (
    .clk(clk), .rst_n(rst_n), .inc_i(frm_inc), .count_o(frame_cnt)
  );

  fbc_event_counter #(.CNT_W(CNT_W)) u_loss_cnt (
    .clk(clk), .rst_n(rst_n), .inc_i(loss_inc), .count_o(loss_cnt)
  );

  fbc_sticky_flag u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(irq_clr), .flag_o(irq_o)
  );

  fbc_frame_slot #(.IS_READER(IS_READER)) u_slot (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_i        (evt_stored),
    .ack_i        (ack_fire),
    .cap_fields_i ({cap_ilace, cap_width, cap_height}),
    .cap_addr_i   (cap_addr),
    .sw_info_we_i (wr_info),
    .sw_addr_we_i (wr_addr),
    .sw_wdata_i   (bus_wdata),
    .accept_o     (cap_accept),
    .avail_o      (frame_avail_o),
    .fields_o     (slot_fields),
    .addr_o       (frame_addr_o)
  );

  assign fcnt_word    = 32'(frame_cnt);
  assign lcnt_word    = 32'(loss_cnt);
  assign frame_word_o = pack_info(frame_avail_o, slot_fields);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q  <= ~RUN_CTRL;
      aff_q <= 1'b0;
      dly_q <= DELAY_W'(1);
      ack_q <= 1'b0;
    end else begin
      if (wr_ctrl) go_q <= bus_wdata[0];
      if (wr_misc) begin
        aff_q <= bus_wdata[1];
        dly_q <= norm_delay(bus_wdata[16 +: DELAY_W]);
      end
      ack_q <= ack_fire;
    end
  end

  assign go_o       = go_q;
  assign ack_o      = ack_q;
  assign affinity_o = aff_q;
  assign delay_o    = dly_q;

  always_comb begin
    rd_word = '0;
    case (bus_addr)
      AD_CTRL: rd_word = {31'b0, go_q};
      AD_STAT: rd_word = {31'b0, dp_busy};
      AD_IRQ:  rd_word = {31'b0, irq_o};
      AD_FCNT: rd_word = fcnt_word;
      AD_LCNT: rd_word = lcnt_word;
      AD_INFO: rd_word = frame_word_o;
      AD_ADDR: rd_word = frame_addr_o;
      AD_CAPS: rd_word = IS_READER ? pack_caps(rd_ready, CAP_W, CAP_H) : 32'b0;
      AD_MISC: rd_word = pack_misc(aff_q, dly_q);
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

endmodule

// File: rtl/fbc_checker.sv
module fbc_checker
  import fbc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               role_rd,
  input logic               irq_set,
  input logic               irq_clr,
  input logic               irq_o,
  input logic               frm_inc,
  input logic [31:0]        fcnt_word,
  input logic               ack_fire,
  input logic               ack_o,
  input logic               frame_avail_o,
  input logic [31:0]        frame_addr_o,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_rdata,
  input logic [DELAY_W-1:0] delay_o
);
  p_irq_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq_o);

  p_irq_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_set) |=> !irq_o);

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_inc |=> $stable(fcnt_word));

  p_record_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!role_rd && frame_avail_o && !ack_fire) |=> $stable(frame_addr_o));

  p_ack_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(ack_fire));

  p_ack_reader_r6: assert property (@(posedge clk) disable iff (!rst_n)
    role_rd |-> !ack_o);

  p_delay_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    delay_o != '0);

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr > ADDR_W'(OFS_MISC))) |=> (bus_rdata == 32'b0));
endmodule

bind fbuf_ctrl_regs fbc_checker #(.ADDR_W(ADDR_W)) u_fbc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .role_rd       (role_rd),
  .irq_set       (irq_set),
  .irq_clr       (irq_clr),
  .irq_o         (irq_o),
  .frm_inc       (frm_inc),
  .fcnt_word     (fcnt_word),
  .ack_fire      (ack_fire),
  .ack_o         (ack_o),
  .frame_avail_o (frame_avail_o),
  .frame_addr_o  (frame_addr_o),
  .bus_rd        (bus_rd),
  .bus_addr      (bus_addr),
  .bus_rdata     (bus_rdata),
  .delay_o       (delay_o)
);

// File: tb/fbuf_ctrl_regs_bench.sv
`timescale 1ns/1ps
module fbuf_ctrl_regs_bench;
  localparam int MAXW = 1920;
  localparam int MAXH = 1080;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        evt_stored = 0, evt_fetched = 0, evt_dropped = 0, evt_repeated = 0;
  logic        dp_busy = 0, rd_ready = 0;
  logic [3:0]  cap_ilace = '0;
  logic [12:0] cap_width = '0, cap_height = '0;
  logic [31:0] cap_addr = '0;

  logic [31:0] rdata_w, rdata_r, fword_w, fword_r, faddr_w, faddr_r;
  logic        go_w, go_r, irq_w, irq_r, ack_w, ack_r, av_w, av_r, aff_w, aff_r;
  logic [11:0] dly_w, dly_r;

  fbuf_ctrl_regs #(.IS_READER(1'b0), .MAX_W(MAXW), .MAX_H(MAXH)) u_fbuf_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_w), .evt_stored(evt_stored),
    .evt_fetched(evt_fetched), .evt_dropped(evt_dropped), .evt_repeated(evt_repeated),
    .dp_busy(dp_busy), .cap_ilace(cap_ilace), .cap_width(cap_width),
    .cap_height(cap_height), .cap_addr(cap_addr), .rd_ready(rd_ready),
    .go_o(go_w), .irq_o(irq_w), .ack_o(ack_w), .frame_avail_o(av_w),
    .frame_word_o(fword_w), .frame_addr_o(faddr_w), .affinity_o(aff_w), .delay_o(dly_w)
  );

  fbuf_ctrl_regs #(.IS_READER(1'b1), .MAX_W(MAXW), .MAX_H(MAXH)) u_fbuf_ctrl_regs_rd (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_r), .evt_stored(evt_stored),
    .evt_fetched(evt_fetched), .evt_dropped(evt_dropped), .evt_repeated(evt_repeated),
    .dp_busy(dp_busy), .cap_ilace(cap_ilace), .cap_width(cap_width),
    .cap_height(cap_height), .cap_addr(cap_addr), .rd_ready(rd_ready),
    .go_o(go_r), .irq_o(irq_r), .ack_o(ack_r), .frame_avail_o(av_r),
    .frame_word_o(fword_r), .frame_addr_o(faddr_r), .affinity_o(aff_r), .delay_o(dly_r)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // Bench model
  bit          m_go, m_aff, m_irq_w, m_irq_r, m_av, m_ack;
  logic [11:0] m_dly;
  logic [31:0] m_fc_w, m_dc_w, m_fc_r, m_rc_r, m_addr_w, m_addr_r;
  logic [29:0] m_info_w, m_info_r;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] a, input bit rdr);
    case (a)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return rdr ? "R7" : "R5";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] exp_word(input bit rdr, input logic [3:0] a);
    case (a)
      4'd0: return {31'b0, m_go};
      4'd1: return {31'b0, dp_busy};
      4'd2: return {31'b0, rdr ? m_irq_r : m_irq_w};
      4'd3: return rdr ? m_fc_r : m_fc_w;
      4'd4: return rdr ? m_rc_r : m_dc_w;
      4'd5: return rdr ? {2'b00, m_info_r} : {m_av, 1'b0, m_info_w};
      4'd6: return rdr ? m_addr_r : m_addr_w;
      4'd7: return rdr ? {5'b0, rd_ready, 13'(MAXW), 13'(MAXH)} : 32'b0;
      4'd8: return {4'b0, m_dly, 14'b0, m_aff, 1'b0};
      default: return 32'b0;
    endcase
  endfunction

  function automatic void model_step(input bit wr, input logic [3:0] a, input logic [31:0] d,
                                     input bit st, input bit fe, input bit dr, input bit rp);
    bit ackf, accept;
    ackf   = wr && a == 4'd8 && d[0];
    accept = st && (!m_av || ackf);
    if (accept) begin
      m_info_w = {cap_ilace, cap_width, cap_height};
      m_addr_w = cap_addr;
    end
    m_av    = accept || (m_av && !ackf);
    m_ack   = ackf;
    m_irq_w = st || (m_irq_w && !(wr && a == 4'd2 && d[0]));
    m_irq_r = fe || (m_irq_r && !(wr && a == 4'd2 && d[0]));
    m_fc_w += 32'(st);
    m_dc_w += 32'(dr);
    m_fc_r += 32'(fe);
    m_rc_r += 32'(rp);
    if (wr && a == 4'd0) m_go = d[0];
    if (wr && a == 4'd8) begin
      m_aff = d[1];
      m_dly = (d[27:16] == 12'd0) ? 12'd1 : d[27:16];
    end
    if (wr && a == 4'd5) m_info_r = d[29:0];
    if (wr && a == 4'd6) m_addr_r = d;
  endfunction

  task automatic out_checks();
    chk("R1", "go_o writer", 32'(go_w), 32'(m_go));
    chk("R1", "go_o reader", 32'(go_r), 32'(m_go));
    chk("R3", "irq_o writer", 32'(irq_w), 32'(m_irq_w));
    chk("R3", "irq_o reader", 32'(irq_r), 32'(m_irq_r));
    chk("R6", "ack_o writer", 32'(ack_w), 32'(m_ack));
    chk("R6", "ack_o reader", 32'(ack_r), 32'd0);
    chk("R5", "frame_avail_o", 32'(av_w), 32'(m_av));
    chk("R5", "frame_word_o writer", fword_w, {m_av, 1'b0, m_info_w});
    chk("R5", "frame_addr_o writer", faddr_w, m_addr_w);
    chk("R7", "frame_word_o reader", fword_r, {2'b00, m_info_r});
    chk("R7", "frame_addr_o reader", faddr_r, m_addr_r);
    chk("R8", "affinity_o", 32'(aff_w), 32'(m_aff));
    chk("R8", "delay_o", 32'(dly_r), 32'(m_dly));
  endtask

  // One bus/event cycle: driven at a falling edge, results sampled at the next
  task automatic cyc(input bit wr, input logic [3:0] a, input logic [31:0] d, input bit rd,
                     input bit st, input bit fe, input bit dr, input bit rp);
    logic [31:0] ew, er;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; bus_rd = rd;
    evt_stored = st; evt_fetched = fe; evt_dropped = dr; evt_repeated = rp;
    ew = exp_word(1'b0, a);
    er = exp_word(1'b1, a);
    model_step(wr, a, d, st, fe, dr, rp);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    evt_stored = 0; evt_fetched = 0; evt_dropped = 0; evt_repeated = 0;
    if (rd) begin
      chk(tag_of(a, 1'b0), $sformatf("read word %0d writer", a), rdata_w, ew);
      chk(tag_of(a, 1'b1), $sformatf("read word %0d reader", a), rdata_r, er);
    end
    out_checks();
  endtask

  task automatic rd_only(input logic [3:0] a);
    cyc(1'b0, a, 32'b0, 1'b1, 0, 0, 0, 0);
  endtask

  task automatic wr_only(input logic [3:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20417));
    m_go = 0; m_aff = 0; m_irq_w = 0; m_irq_r = 0; m_av = 0; m_ack = 0; m_dly = 12'd1;
    m_fc_w = 0; m_dc_w = 0; m_fc_r = 0; m_rc_r = 0; m_addr_w = 0; m_addr_r = 0;
    m_info_w = 0; m_info_r = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: go low, flag low, delay 1 (R1, R3, R8)
    out_checks();
    for (int a = 0; a < 16; a++) rd_only(4'(a));

    // R1 run enable write and read back
    wr_only(4'd0, 32'hFFFF_FFFF);
    rd_only(4'd0);
    wr_only(4'd0, 32'h0000_0002);
    rd_only(4'd0);

    // R2 status mirrors dp_busy, writes ignored
    dp_busy = 1; rd_only(4'd1);
    wr_only(4'd1, 32'hFFFF_FFFF);
    dp_busy = 0; rd_only(4'd1);

    // R3 set, clear, set-wins
    cyc(0, 4'd0, 0, 0, 1, 1, 0, 0);
    rd_only(4'd2);
    wr_only(4'd2, 32'h1);
    rd_only(4'd2);
    cyc(1, 4'd2, 32'h1, 0, 1, 1, 0, 0);
    rd_only(4'd2);
    wr_only(4'd2, 32'h0);

    // R4 counters and ignored strobes / writes
    cyc(0, 4'd0, 0, 0, 0, 0, 1, 1);
    wr_only(4'd3, 32'h1234_5678);
    wr_only(4'd4, 32'h1234_5678);
    rd_only(4'd3); rd_only(4'd4);

    // R5 capture when free, hold while available
    cap_ilace = 4'hA; cap_width = 13'd1280; cap_height = 13'd720; cap_addr = 32'h8000_0000;
    wr_only(4'd6, 32'h0);          // writer ignores, reader loads 0
    rd_only(4'd5); rd_only(4'd6);
    cap_ilace = 4'h3; cap_width = 13'd640; cap_height = 13'd480; cap_addr = 32'h9000_1000;
    cyc(0, 4'd0, 0, 0, 1, 0, 0, 0);
    rd_only(4'd5); rd_only(4'd6);

    // R6 acknowledge pulse, then low, then ack with store in same cycle
    wr_only(4'd8, 32'h0001_0001);
    cyc(0, 4'd0, 0, 0, 0, 0, 0, 0);
    rd_only(4'd8);
    cap_addr = 32'hA000_2000;
    cyc(0, 4'd0, 0, 0, 1, 0, 0, 0);
    cap_addr = 32'hB000_3000; cap_width = 13'd8191;
    cyc(1, 4'd8, 32'h0001_0001, 0, 1, 0, 0, 0);
    rd_only(4'd6);

    // R7 reader descriptor and capability word
    wr_only(4'd5, 32'hFFFF_FFFF);
    wr_only(4'd6, 32'hDEAD_BEEF);
    rd_only(4'd5); rd_only(4'd6);
    rd_ready = 1; rd_only(4'd7);
    rd_ready = 0; rd_only(4'd7);

    // R8 delay floor and range ends
    wr_only(4'd8, 32'h0000_0002); rd_only(4'd8);
    wr_only(4'd8, 32'h0FFF_0000); rd_only(4'd8);
    wr_only(4'd8, 32'h0002_0002); rd_only(4'd8);

    // R9 unmapped words
    wr_only(4'd12, 32'hFFFF_FFFF);
    rd_only(4'd9); rd_only(4'd15);

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      bit wr, rd, st, fe, dr, rp;
      logic [3:0] a;
      logic [31:0] d;
      cap_ilace  = 4'($urandom);
      cap_width  = 13'($urandom);
      cap_height = 13'($urandom);
      cap_addr   = $urandom;
      dp_busy    = 1'($urandom);
      rd_ready   = 1'($urandom);
      wr = ($urandom % 3) == 0;
      rd = ($urandom % 2) == 0;
      a  = 4'($urandom % 11);
      d  = $urandom;
      if (($urandom % 4) == 0) d[27:16] = 12'd0;
      st = ($urandom % 3) == 0;
      fe = ($urandom % 3) == 0;
      dr = ($urandom % 4) == 0;
      rp = ($urandom % 4) == 0;
      cyc(wr, a, d, rd, st, fe, dr, rp);
    end
    for (int a = 0; a < 11; a++) rd_only(4'(a));

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule